// File: doc/BRIEF.md
# Package Sleep-State Sequencer

This block follows the low-power state of a processor package. Four active-low request pins drive it: stop-clock, sleep, deep-sleep and deeper-sleep. The states form a strict ladder: Normal, Stop-Grant, Sleep, Deep Sleep and Deeper Sleep. Each rung is entered when the pin that belongs to it asserts and left when that same pin releases. Stop-Grant has one side state, Stop-Grant-Snoop. The block moves there when a bus snoop arrives and returns once the snoop has been serviced.

Every pin passes through a hold filter. A new level counts only after it has been sampled on several consecutive bus clocks. From the current state the block drives three enables: core clock, snoop acceptance and interrupt acceptance. It also watches the pin protocol and sets a sticky violation flag when a rule is broken. Two rules are checked: a request that asserts out of ladder order, and a stop-clock release that follows the sleep release too closely.

Top module: `pkg_sleep_seq`

## Requirements
- R1: With default parameters, the state code reads 0 for Normal and 1 for Stop-Grant. Normal moves to Stop-Grant when the recognized stop-clock request asserts. Stop-Grant returns to Normal when that request is recognized as released.
- R2: A new level on a request pin is recognized only after it has been sampled on 3 consecutive rising clock edges (MIN_HOLD). The state changes on the next edge, so it is visible 4 edges after the pin changes. A pulse or glitch that lasts 1 or 2 edges has no effect on the state.
- R3: The state codes are 3 for Sleep, 4 for Deep Sleep and 5 for Deeper Sleep. Sleep is entered from Stop-Grant when the sleep request asserts. Deep Sleep is entered from Sleep when the deep-sleep request asserts. Deeper Sleep is entered from Deep Sleep when the deeper-sleep request asserts. Releasing the same pin steps back one rung.
- R4: Stop-Grant-Snoop has state code 2. From Stop-Grant, a high snoopReq sampled on an edge enters it on that edge. A high snoopDone returns the block to Stop-Grant. snoopReq has no effect in any other state.
- R5: The enables {coreClkEn, snoopEn, intEn} depend on the state. They read 1,1,1 in Normal and Stop-Grant-Snoop, 0,1,1 in Stop-Grant, and 0,0,0 in Sleep, Deep Sleep and Deeper Sleep.
- R6: A request that is recognized as asserting in a state other than the one just above it on the ladder is ignored. The state does not change, and protoViol is set.
- R7: The stop-clock release must be recognized at least GAP_MIN (10) edges after the sleep release. If it is recognized fewer than 10 edges after, the block still returns to Normal but sets protoViol.
- R8: During a synchronous active-low reset, the state loads 1 (Stop-Grant) if stopReqN is low and 0 (Normal) otherwise. Reset clears protoViol, which otherwise stays set once raised.
- R9: stateChg is high for exactly the one cycle in which a new state code first appears, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous reset, active low |
| stopReqN | input | 1 | Stop-clock request, active low |
| sleepReqN | input | 1 | Sleep request, active low |
| deepReqN | input | 1 | Deep-sleep request, active low |
| deeperReqN | input | 1 | Deeper-sleep request, active low |
| snoopReq | input | 1 | A snoop is pending on the bus |
| snoopDone | input | 1 | The pending snoop has been serviced |
| stateCode | output | 3 | Encoded package state |
| stateChg | output | 1 | One-cycle marker of a state change |
| coreClkEn | output | 1 | Internal core clock enable |
| snoopEn | output | 1 | Snoop acceptance enable |
| intEn | output | 1 | Interrupt acceptance enable |
| protoViol | output | 1 | Sticky pin-protocol violation flag |

## Verification
A wrong state shows on stateCode and the three enables on the very next edge. Every pin change is therefore checked on the exact fourth edge, with the third edge checked as a boundary, so a filter that is one edge short or long is caught. Bad ladder bookkeeping shows later and less directly: a release that picks the wrong rung, a snoop return to the wrong place, or a false violation from the gap timer. For this reason the bench sweeps pulse lengths, sleep-to-stop gaps and out-of-order pins, and reads protoViol after each.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int NUM_REQ    = 4;
  localparam int REQ_STOP   = 0;
  localparam int REQ_SLEEP  = 1;
  localparam int REQ_DEEP   = 2;
  localparam int REQ_DEEPER = 3;

  typedef enum logic [2:0] {
    ST_NORMAL  = 3'd0,
    ST_STOPGNT = 3'd1,
    ST_SNOOP   = 3'd2,
    ST_SLEEP   = 3'd3,
    ST_DEEP    = 3'd4,
    ST_DEEPER  = 3'd5
  } pssState_t;

  // datapath -> control
  typedef struct packed {
    logic [NUM_REQ-1:0] lvl;
    logic [NUM_REQ-1:0] rise;
    logic               gapShort;
  } pssStat_t;

  // control -> datapath
  typedef struct packed {
    logic gapStart;
  } pssStrobe_t;
endpackage

// File: rtl/pss_hold_filter.sv
module pss_hold_filter #(
  parameter int MIN_HOLD = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawAct,
  output logic lvl,
  output logic rise
);
  localparam int CW = $clog2(MIN_HOLD) + 1;

  logic [CW-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvl     <= rawAct;
      holdCnt <= '0;
      rise    <= 1'b0;
    end else begin
      rise <= 1'b0;
      if (rawAct == lvl) begin
        holdCnt <= '0;
      end else if (holdCnt == CW'(MIN_HOLD - 1)) begin
        lvl     <= rawAct;
        holdCnt <= '0;
        rise    <= rawAct;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

  // R2: a recognized level always matches the pin sampled on the previous edge
  a_r2_level_follows_pin: assert property (@(posedge clk) disable iff (!rstN)
    (lvl != $past(lvl)) |-> (lvl == $past(rawAct)));

  // R2: a rise marker only accompanies an asserted level
  a_r2_rise_with_level: assert property (@(posedge clk) disable iff (!rstN)
    rise |-> lvl);
endmodule

// File: rtl/pss_datapath.sv
module pss_datapath
  import pss_pkg::*;
#(
  parameter int MIN_HOLD = 3,
  parameter int GAP_MIN  = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqN,
  input  pssStrobe_t         strobe,
  output pssStat_t           stat
);
  localparam int GW = $clog2(GAP_MIN + 1);

  logic [NUM_REQ-1:0] lvlVec;
  logic [NUM_REQ-1:0] riseVec;
  logic [GW-1:0]      gapCnt;

  for (genvar g = 0; g < NUM_REQ; g++) begin : gFilt
    pss_hold_filter #(.MIN_HOLD(MIN_HOLD)) uFilt (
      .clk    (clk),
      .rstN   (rstN),
      .rawAct (~reqN[g]),
      .lvl    (lvlVec[g]),
      .rise   (riseVec[g])
    );
  end

  // edges elapsed since the sleep release was acted on; saturates at GAP_MIN
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= GW'(GAP_MIN);
    end else if (strobe.gapStart) begin
      gapCnt <= GW'(1);
    end else if (gapCnt < GW'(GAP_MIN)) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  always_comb begin
    stat.lvl      = lvlVec;
    stat.rise     = riseVec;
    stat.gapShort = (gapCnt < GW'(GAP_MIN));
  end

  // R7: the gap timer never runs past its limit
  a_r7_gap_bound: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt <= GW'(GAP_MIN));

  // R7: a fresh sleep exit always opens a short window
  a_r7_gap_opens: assert property (@(posedge clk) disable iff (!rstN)
    strobe.gapStart |=> stat.gapShort);
endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rstStopAct,
  input  pssStat_t   stat,
  input  logic       snoopReq,
  input  logic       snoopDone,
  output pssStrobe_t strobe,
  output pssState_t  state,
  output logic       stateChg,
  output logic       coreClkEn,
  output logic       snoopEn,
  output logic       intEn,
  output logic       protoViol
);
  pssState_t          nxt;
  logic               badStep;
  logic [NUM_REQ-1:0] legalRise;

  function automatic logic [NUM_REQ-1:0] riseMask(pssState_t s);
    logic [NUM_REQ-1:0] m;
    m = '0;
    case (s)
      ST_NORMAL:  m[REQ_STOP]   = 1'b1;
      ST_STOPGNT: m[REQ_SLEEP]  = 1'b1;
      ST_SLEEP:   m[REQ_DEEP]   = 1'b1;
      ST_DEEP:    m[REQ_DEEPER] = 1'b1;
      default:    m = '0;
    endcase
    return m;
  endfunction

  always_comb begin
    nxt       = state;
    legalRise = riseMask(state);
    badStep   = |(stat.rise & ~legalRise);
    case (state)
      ST_NORMAL:  if (stat.rise[REQ_STOP]) nxt = ST_STOPGNT;
      ST_STOPGNT: begin
        if (!stat.lvl[REQ_STOP]) begin
          nxt     = ST_NORMAL;
          badStep = badStep | stat.gapShort;
        end else if (stat.rise[REQ_SLEEP]) begin
          nxt = ST_SLEEP;
        end else if (snoopReq) begin
          nxt = ST_SNOOP;
        end
      end
      ST_SNOOP:   if (snoopDone) nxt = ST_STOPGNT;
      ST_SLEEP: begin
        if (!stat.lvl[REQ_SLEEP])    nxt = ST_STOPGNT;
        else if (stat.rise[REQ_DEEP]) nxt = ST_DEEP;
      end
      ST_DEEP: begin
        if (!stat.lvl[REQ_DEEP])        nxt = ST_SLEEP;
        else if (stat.rise[REQ_DEEPER]) nxt = ST_DEEPER;
      end
      ST_DEEPER:  if (!stat.lvl[REQ_DEEPER]) nxt = ST_DEEP;
      default:    nxt = ST_NORMAL;
    endcase
    strobe.gapStart = (state == ST_SLEEP) && (nxt == ST_STOPGNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= rstStopAct ? ST_STOPGNT : ST_NORMAL;
      stateChg  <= 1'b0;
      protoViol <= 1'b0;
    end else begin
      state     <= nxt;
      stateChg  <= (nxt != state);
      protoViol <= protoViol | badStep;
    end
  end

  always_comb begin
    coreClkEn = (state == ST_NORMAL) || (state == ST_SNOOP);
    snoopEn   = (state == ST_NORMAL) || (state == ST_STOPGNT) || (state == ST_SNOOP);
    intEn     = snoopEn;
  end

  // R1: Normal only ever steps to Stop-Grant
  a_r1_normal_step: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NORMAL) |=> (state inside {ST_NORMAL, ST_STOPGNT}));

  // R3: Sleep and Deep Sleep move one rung at a time
  a_r3_sleep_step: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP) |=> (state inside {ST_SLEEP, ST_STOPGNT, ST_DEEP}));
  a_r3_deep_step: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEEP) |=> (state inside {ST_DEEP, ST_SLEEP, ST_DEEPER}));

  // R4: the snoop side state waits for completion
  a_r4_snoop_wait: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SNOOP && !snoopDone) |=> (state == ST_SNOOP));

  // R6: an out-of-order request in Normal leaves the state alone
  a_r6_normal_ignores: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NORMAL && !stat.rise[REQ_STOP]) |=> (state == ST_NORMAL));

  // R8: the violation flag holds until reset
  a_r8_viol_sticky: assert property (@(posedge clk) disable iff (!rstN)
    protoViol |=> protoViol);

  // R9: the change marker coincides with a new state code
  a_r9_chg_marks: assert property (@(posedge clk) disable iff (!rstN)
    stateChg |-> (state != $past(state)));
endmodule

// File: rtl/pkg_sleep_seq.sv
module pkg_sleep_seq
  import pss_pkg::*;
#(
  parameter int MIN_HOLD = 3,
  parameter int GAP_MIN  = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopReqN,
  input  logic       sleepReqN,
  input  logic       deepReqN,
  input  logic       deeperReqN,
  input  logic       snoopReq,
  input  logic       snoopDone,
  output logic [2:0] stateCode,
  output logic       stateChg,
  output logic       coreClkEn,
  output logic       snoopEn,
  output logic       intEn,
  output logic       protoViol
);
  pssStat_t   stat;
  pssStrobe_t strobe;
  pssState_t  state;

  logic [NUM_REQ-1:0] reqN;
  assign reqN = {deeperReqN, deepReqN, sleepReqN, stopReqN};

  pss_datapath #(.MIN_HOLD(MIN_HOLD), .GAP_MIN(GAP_MIN)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .reqN   (reqN),
    .strobe (strobe),
    .stat   (stat)
  );

  pss_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .rstStopAct (~stopReqN),
    .stat       (stat),
    .snoopReq   (snoopReq),
    .snoopDone  (snoopDone),
    .strobe     (strobe),
    .state      (state),
    .stateChg   (stateChg),
    .coreClkEn  (coreClkEn),
    .snoopEn    (snoopEn),
    .intEn      (intEn),
    .protoViol  (protoViol)
  );

  assign stateCode = state;
endmodule

// File: tb/sim_pkg_sleep_seq.sv
module sim_pkg_sleep_seq;
  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] reqN;
  logic       snoopReq, snoopDone;
  logic [2:0] stateCode;
  logic       stateChg, coreClkEn, snoopEn, intEn, protoViol;

  int nChk = 0;
  int nErr = 0;

  always #4 clk = ~clk;

  pkg_sleep_seq u0 (
    .clk        (clk),
    .rstN       (rstN),
    .stopReqN   (reqN[0]),
    .sleepReqN  (reqN[1]),
    .deepReqN   (reqN[2]),
    .deeperReqN (reqN[3]),
    .snoopReq   (snoopReq),
    .snoopDone  (snoopDone),
    .stateCode  (stateCode),
    .stateChg   (stateChg),
    .coreClkEn  (coreClkEn),
    .snoopEn    (snoopEn),
    .intEn      (intEn),
    .protoViol  (protoViol)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int expEn(input int code);
    case (code)
      0, 2:    return 7;
      1:       return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int enNow();
    return int'({coreClkEn, snoopEn, intEn});
  endfunction

  task automatic doReset(input bit stopLow);
    rstN = 1'b0;
    reqN = 4'b1111;
    reqN[0] = ~stopLow;
    snoopReq = 1'b0;
    snoopDone = 1'b0;
    cyc(2);
    rstN = 1'b1;
  endtask

  // drive one pin and check the state on the exact edge it should change
  task automatic stepPin(input int idx, input bit act, input int expState, input string tag);
    reqN[idx] = ~act;
    cyc(3);
    chk({tag, " before change"}, int'(stateCode), int'(stateCode) == expState ? -1 : int'(stateCode));
    cyc(1);
    chk({tag, " state"}, int'(stateCode), expState);
    chk("R9 change pulse", int'(stateChg), 1);
    chk("R5 enables", enNow(), expEn(expState));
    cyc(1);
    chk("R9 pulse ends", int'(stateChg), 0);
  endtask

  initial begin
    #(8 * 100000);
    nErr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    int prevState;
    rstN = 1'b0; reqN = 4'b1111; snoopReq = 1'b0; snoopDone = 1'b0;

    // R8 reset with stop released
    doReset(1'b0);
    chk("R8 reset state normal", int'(stateCode), 0);
    chk("R8 reset viol", int'(protoViol), 0);
    chk("R9 reset chg", int'(stateChg), 0);
    chk("R5 normal enables", enNow(), 7);

    // R1 stop-clock enter/exit with boundary at the third edge
    reqN[0] = 1'b0;
    cyc(3);
    chk("R2 not yet at edge 3", int'(stateCode), 0);
    cyc(1);
    chk("R1 enter stop-grant", int'(stateCode), 1);
    chk("R9 pulse on change", int'(stateChg), 1);
    chk("R5 stop-grant enables", enNow(), 3);
    cyc(1);
    chk("R9 pulse one cycle", int'(stateChg), 0);
    // R2 release glitch of 2 edges is rejected
    reqN[0] = 1'b1; cyc(2); reqN[0] = 1'b0; cyc(6);
    chk("R2 release glitch ignored", int'(stateCode), 1);
    chk("R9 no pulse after glitch", int'(stateChg), 0);
    reqN[0] = 1'b1;
    cyc(3);
    chk("R2 release not yet", int'(stateCode), 1);
    cyc(1);
    chk("R1 back to normal", int'(stateCode), 0);
    chk("R7 long gap no viol", int'(protoViol), 0);

    // R2 sweep of assertion pulse lengths
    for (int len = 1; len <= 5; len++) begin
      doReset(1'b0);
      reqN[0] = 1'b0;
      cyc(len < 4 ? len : 4);
      if (len < 4) begin
        reqN[0] = 1'b1;
        cyc(4 - len);
      end
      chk($sformatf("R2 pulse len %0d", len), int'(stateCode), (len >= 3) ? 1 : 0);
      cyc(8);
    end

    // R8 reset with stop held, then the ladder R3
    doReset(1'b1);
    chk("R8 reset into stop-grant", int'(stateCode), 1);
    chk("R8 reset viol clear", int'(protoViol), 0);
    reqN[1] = 1'b0; cyc(4);
    chk("R3 enter sleep", int'(stateCode), 3);
    chk("R5 sleep enables", enNow(), 0);
    reqN[2] = 1'b0; cyc(4);
    chk("R3 enter deep", int'(stateCode), 4);
    reqN[3] = 1'b0; cyc(4);
    chk("R3 enter deeper", int'(stateCode), 5);
    chk("R5 deeper enables", enNow(), 0);
    snoopReq = 1'b1; cyc(2); snoopReq = 1'b0;
    chk("R4 snoop ignored in deeper", int'(stateCode), 5);
    reqN[3] = 1'b1; cyc(4);
    chk("R3 exit deeper", int'(stateCode), 4);
    reqN[2] = 1'b1; cyc(4);
    chk("R3 exit deep", int'(stateCode), 3);
    chk("R6 legal ladder no viol", int'(protoViol), 0);

    // R4 snoop side state from stop-grant
    doReset(1'b1);
    snoopReq = 1'b1; cyc(1); snoopReq = 1'b0;
    chk("R4 enter snoop", int'(stateCode), 2);
    chk("R5 snoop enables", enNow(), 7);
    cyc(3);
    chk("R4 wait for done", int'(stateCode), 2);
    snoopDone = 1'b1; cyc(1); snoopDone = 1'b0;
    chk("R4 back to stop-grant", int'(stateCode), 1);
    doReset(1'b0);
    snoopReq = 1'b1; cyc(3); snoopReq = 1'b0;
    chk("R4 snoop ignored in normal", int'(stateCode), 0);

    // R6 out-of-order requests from Normal
    for (int idx = 1; idx <= 3; idx++) begin
      doReset(1'b0);
      reqN[idx] = 1'b0; cyc(6);
      chk($sformatf("R6 pin %0d ignored in normal", idx), int'(stateCode), 0);
      chk($sformatf("R6 pin %0d flags", idx), int'(protoViol), 1);
    end
    // R6 deep request straight from stop-grant, then flag stays (R8)
    doReset(1'b1);
    reqN[2] = 1'b0; cyc(6);
    chk("R6 deep ignored in stop-grant", int'(stateCode), 1);
    chk("R6 deep flags", int'(protoViol), 1);
    reqN[2] = 1'b1; reqN[0] = 1'b1; cyc(6);
    chk("R8 flag sticky", int'(protoViol), 1);
    doReset(1'b0);
    chk("R8 reset clears flag", int'(protoViol), 0);

    // R7 sweep of the sleep-to-stop release gap
    for (int d = 0; d <= 14; d++) begin
      doReset(1'b1);
      reqN[1] = 1'b0; cyc(4);
      prevState = int'(stateCode);
      reqN[1] = 1'b1;
      if (d > 0) cyc(d);
      reqN[0] = 1'b1;
      cyc(20);
      chk($sformatf("R7 gap %0d sleep reached", d), prevState, 3);
      chk($sformatf("R7 gap %0d final state", d), int'(stateCode), 0);
      chk($sformatf("R7 gap %0d viol", d), int'(protoViol), (d < 10) ? 1 : 0);
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule